// File: doc/BRIEF.md
# Edge-Triggered Dual Capture Unit

This block watches an asynchronous event line and records the value of an external running counter when that line makes a transition of the selected polarity. The line is first brought into the functional clock domain by a flop chain. Edges are then qualified by a two-bit edge mode: off, rising, falling, or both.

A mode bit picks one of two sequences. The single sequence records one edge into the first capture register. The dual sequence records two consecutive edges into the first and then the second capture register, so software can take the difference as a period. When a sequence completes, the unit raises a status flag and ignores every further edge until it is re-armed. It can also drive an interrupt line, gated by an enable input.

Re-arming happens in one of two ways. Software can write a one to the flag while the flag is set. Alternatively, the edge mode can move away from "off" to any active setting.

Top module: `evcap_unit`

## Requirements
- R1: `edge_mode_i` selects which synchronized transitions count as events: 0 = none, 1 = rising, 2 = falling, 3 = both. With mode 0 no capture register or flag changes.
- R2: With `dual_mode_i` = 0, the first event after arming stores the counter into `cap1_o` and sets `flag_o`.
- R3: With `dual_mode_i` = 1, the first event stores into `cap1_o` without setting the flag. The second event stores into `cap2_o` and sets `flag_o`.
- R4: A change of `event_i` is captured on the third rising clock edge after the change. The stored value is `count_i` as sampled at that same edge.
- R5: While `flag_o` is set, further events change neither capture register.
- R6: A cycle with `clr_we_i` = 1 and `clr_val_i` = 1 while `flag_o` is set clears the flag on the next edge and re-arms the unit. A write with `clr_val_i` = 0 has no effect.
- R7: When a clearing write and an event fall in the same cycle, the clear wins. The event is dropped, so no capture register changes and the flag ends cleared.
- R8: A change of `edge_mode_i` from 0 to any non-zero value clears the flag and re-arms the unit. An event in that same cycle is dropped.
- R9: `irq_o` equals `flag_o` AND `irq_en_i`.
- R10: An input pulse lasting one clock period is detected, including both of its edges in mode 3.
- R11: After reset both capture registers, `flag_o` and `irq_o` are 0 and the unit is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| event_i | input | 1 | Asynchronous event line |
| count_i | input | CNT_W | Running counter value to record |
| edge_mode_i | input | 2 | Edge polarity selection (0 none, 1 rise, 2 fall, 3 both) |
| dual_mode_i | input | 1 | 0 = single capture, 1 = two-capture sequence |
| irq_en_i | input | 1 | Interrupt enable |
| clr_we_i | input | 1 | Write strobe for the status flag |
| clr_val_i | input | 1 | Write data for the status flag; 1 clears it |
| cap1_o | output | CNT_W | First capture register |
| cap2_o | output | CNT_W | Second capture register |
| flag_o | output | 1 | Sequence-complete status flag |
| irq_o | output | 1 | Capture interrupt |

## Verification
The case that can coincide is a re-arming write to the flag landing in the same cycle that a synchronized edge is detected. The bench provokes it by changing the event line, waiting exactly two clock edges, and then asserting the clearing write so that both meet on the third edge. It judges the result by requiring that the flag ends cleared and the first capture register keeps its old value. It also checks that the next real event is then taken as a fresh first capture.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,
        ST_FIRST  = 2'd1,
        ST_LOCKED = 2'd2
    } seq_state_e;

endpackage

// File: rtl/evcap_sync.sv
module evcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[CHAIN_W-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    assign rise_o =  sync_q.chain[STAGES-1] & ~sync_q.chain[STAGES];
    assign fall_o = ~sync_q.chain[STAGES-1] &  sync_q.chain[STAGES];

endmodule

// File: rtl/evcap_edge_sel.sv
module evcap_edge_sel
    import evcap_pkg::*;
(
    input  edge_mode_e mode_i,
    input  logic       rise_i,
    input  logic       fall_i,
    output logic       hit_o
);
    always_comb begin
        unique case (mode_i)
            EDGE_RISE: hit_o = rise_i;
            EDGE_FALL: hit_o = fall_i;
            EDGE_BOTH: hit_o = rise_i | fall_i;
            default:   hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/evcap_seq.sv
module evcap_seq
    import evcap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hit_i,
    input  logic [CNT_W-1:0] count_i,
    input  edge_mode_e       mode_i,
    input  logic             dual_i,
    input  logic             clr_we_i,
    input  logic             clr_val_i,
    output logic [CNT_W-1:0] cap1_o,
    output logic [CNT_W-1:0] cap2_o,
    output logic             flag_o
);
    typedef struct packed {
        seq_state_e       state;
        logic             was_none;
        logic             flag;
        logic [CNT_W-1:0] cap1;
        logic [CNT_W-1:0] cap2;
    } seq_t;

    seq_t seq_d, seq_q;
    logic clr_hit;
    logic mode_rearm;

    always_comb begin
        seq_d          = seq_q;
        seq_d.was_none = (mode_i == EDGE_NONE);
        clr_hit        = clr_we_i & clr_val_i & seq_q.flag;
        mode_rearm     = seq_q.was_none & (mode_i != EDGE_NONE);

        if (clr_hit || mode_rearm) begin
            // re-arm takes priority over any edge seen in this cycle
            seq_d.state = ST_ARMED;
            seq_d.flag  = 1'b0;
        end else if (hit_i) begin
            unique case (seq_q.state)
                ST_ARMED: begin
                    seq_d.cap1 = count_i;
                    if (dual_i) begin
                        seq_d.state = ST_FIRST;
                    end else begin
                        seq_d.state = ST_LOCKED;
                        seq_d.flag  = 1'b1;
                    end
                end
                ST_FIRST: begin
                    seq_d.cap2  = count_i;
                    seq_d.state = ST_LOCKED;
                    seq_d.flag  = 1'b1;
                end
                default: begin
                    seq_d.state = ST_LOCKED;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q          <= '0;
            seq_q.state    <= ST_ARMED;
            seq_q.was_none <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cap1_o = seq_q.cap1;
    assign cap2_o = seq_q.cap2;
    assign flag_o = seq_q.flag;

endmodule

// File: rtl/evcap_unit.sv
module evcap_unit
    import evcap_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             event_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [1:0]       edge_mode_i,
    input  logic             dual_mode_i,
    input  logic             irq_en_i,
    input  logic             clr_we_i,
    input  logic             clr_val_i,
    output logic [CNT_W-1:0] cap1_o,
    output logic [CNT_W-1:0] cap2_o,
    output logic             flag_o,
    output logic             irq_o
);
    edge_mode_e mode;
    logic       rise;
    logic       fall;
    logic       hit;

    assign mode = edge_mode_e'(edge_mode_i);

    evcap_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (event_i),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    evcap_edge_sel u_sel (
        .mode_i (mode),
        .rise_i (rise),
        .fall_i (fall),
        .hit_o  (hit)
    );

    evcap_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hit_i     (hit),
        .count_i   (count_i),
        .mode_i    (mode),
        .dual_i    (dual_mode_i),
        .clr_we_i  (clr_we_i),
        .clr_val_i (clr_val_i),
        .cap1_o    (cap1_o),
        .cap2_o    (cap2_o),
        .flag_o    (flag_o)
    );

    assign irq_o = flag_o & irq_en_i;

endmodule

// File: rtl/evcap_unit_chk.sv
module evcap_unit_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [1:0]       edge_mode_i,
    input logic             clr_we_i,
    input logic             clr_val_i,
    input logic [CNT_W-1:0] cap1_o,
    input logic [CNT_W-1:0] cap2_o,
    input logic             flag_o
);
    // mode 0 means nothing is captured and the flag cannot rise
    p_none_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_mode_i == 2'd0) |=> ($stable(cap1_o) && $stable(cap2_o) && !$rose(flag_o)));

    // locked sequence holds both registers
    p_locked_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !(clr_we_i && clr_val_i) && $stable(edge_mode_i))
        |=> ($stable(cap1_o) && $stable(cap2_o)));

    // a clearing write on a set flag always lands, even against an edge (R7)
    p_clear_lands_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && clr_we_i && clr_val_i) |=> !flag_o);

    // the flag only falls after a clearing write or on leaving mode 0 (R8)
    p_flag_fall_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(flag_o) |-> ($past(clr_we_i && clr_val_i)
                           || ($past(edge_mode_i) != 2'd0 && $past(edge_mode_i, 2) == 2'd0)));
endmodule

bind evcap_unit evcap_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .edge_mode_i (edge_mode_i),
    .clr_we_i    (clr_we_i),
    .clr_val_i   (clr_val_i),
    .cap1_o      (cap1_o),
    .cap2_o      (cap2_o),
    .flag_o      (flag_o)
);

// File: tb/evcap_unit_test.sv
`timescale 1ns/1ps
module evcap_unit_test;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev = 1'b0;
    logic [CW-1:0] cnt = '0;
    logic [1:0]    emode = 2'd0;
    logic          dual = 1'b0;
    logic          ien = 1'b0;
    logic          cwe = 1'b0;
    logic          cval = 1'b0;
    logic [CW-1:0] cap1, cap2;
    logic          flag, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    evcap_unit #(.CNT_W(CW), .SYNC_STAGES(2)) uut (
        .clk_i(clk), .rst_ni(rst_n), .event_i(ev), .count_i(cnt),
        .edge_mode_i(emode), .dual_mode_i(dual), .irq_en_i(ien),
        .clr_we_i(cwe), .clr_val_i(cval),
        .cap1_o(cap1), .cap2_o(cap2), .flag_o(flag), .irq_o(irq)
    );

    // free-running counter, updated just after each rising edge
    always @(posedge clk) begin
        #2 cnt = cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit            hist[$];
    int            m_state;   // 0 armed, 1 one taken, 2 locked
    bit            m_flag;
    bit            m_prev_none;
    logic [CW-1:0] m_c1, m_c2;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {1'b0, 1'b0, 1'b0};
            m_state = 0; m_flag = 0; m_prev_none = 1;
            m_c1 = '0; m_c2 = '0;
        end else begin
            bit up, dn, act, clr, rearm;
            up  = hist[1] && !hist[2];
            dn  = !hist[1] && hist[2];
            act = (emode == 2'd1 && up) || (emode == 2'd2 && dn) || (emode == 2'd3 && (up || dn));
            clr = cwe && cval && m_flag;
            rearm = m_prev_none && (emode != 2'd0);
            if (clr || rearm) begin
                m_state = 0; m_flag = 0;
            end else if (act) begin
                if (m_state == 0) begin
                    m_c1 = cnt;
                    if (dual) m_state = 1;
                    else begin m_state = 2; m_flag = 1; end
                end else if (m_state == 1) begin
                    m_c2 = cnt; m_state = 2; m_flag = 1;
                end
            end
            m_prev_none = (emode == 2'd0);
            hist.push_front(ev);
            void'(hist.pop_back());
        end
        #5;
        chk(cap1 === m_c1, "R2", cap1, m_c1);
        chk(cap2 === m_c2, "R3", cap2, m_c2);
        chk(flag === m_flag, "R5", flag, m_flag);
        chk(irq === (m_flag & ien), "R9", irq, m_flag & ien);
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        logic [CW-1:0] c0, c1, keep;
        tick(4);
        // R11: reset state
        chk(cap1 == 0 && cap2 == 0, "R11", cap1 | cap2, 0);
        chk(flag == 0 && irq == 0, "R11", flag | irq, 0);
        rst_n = 1'b1;
        tick(2);

        // R2/R4: single capture on rising edge
        emode = 2'd1; dual = 1'b0;
        tick(2);
        ev = 1'b1; c0 = cnt;
        tick(3);
        chk(cap1 == c0 + 2, "R4", cap1, c0 + 2);
        chk(flag == 1, "R2", flag, 1);
        chk(irq == 0, "R9", irq, 0);
        // R5: later edges ignored
        keep = cap1;
        ev = 1'b0; tick(4); ev = 1'b1; tick(5);
        chk(cap1 == keep, "R5", cap1, keep);

        // R6: zero write has no effect, one write clears
        cwe = 1'b1; cval = 1'b0; tick(1); cwe = 1'b0; tick(1);
        chk(flag == 1, "R6", flag, 1);
        cwe = 1'b1; cval = 1'b1; tick(1); cwe = 1'b0; cval = 1'b0; tick(1);
        chk(flag == 0, "R6", flag, 0);

        // R3: dual capture on falling edges, interrupt enabled
        ien = 1'b1; emode = 2'd2; dual = 1'b1;
        ev = 1'b0; c0 = cnt; tick(3);
        chk(cap1 == c0 + 2, "R3", cap1, c0 + 2);
        chk(flag == 0, "R3", flag, 0);
        ev = 1'b1; tick(4);
        ev = 1'b0; c1 = cnt; tick(3);
        chk(cap2 == c1 + 2, "R3", cap2, c1 + 2);
        chk(flag == 1 && irq == 1, "R9", {flag, irq}, 3);

        // R7: clear and a falling edge in the same cycle
        ev = 1'b1; tick(5);
        keep = cap1;
        ev = 1'b0; tick(2);
        cwe = 1'b1; cval = 1'b1; tick(1); cwe = 1'b0; cval = 1'b0; tick(2);
        chk(flag == 0, "R7", flag, 0);
        chk(cap1 == keep, "R7", cap1, keep);
        ev = 1'b1; tick(3); ev = 1'b0; c0 = cnt; tick(3);
        chk(cap1 == c0 + 2, "R7", cap1, c0 + 2);

        // R1/R8: mode 0 ignores events, leaving it re-arms
        ev = 1'b1; tick(4); ev = 1'b0; tick(4);
        chk(flag == 1, "R3", flag, 1);
        emode = 2'd0; tick(2);
        keep = cap1;
        ev = 1'b1; tick(4); ev = 1'b0; tick(4);
        chk(cap1 == keep, "R1", cap1, keep);
        emode = 2'd1; dual = 1'b0; tick(2);
        chk(flag == 0, "R8", flag, 0);
        ev = 1'b1; c0 = cnt; tick(3);
        chk(cap1 == c0 + 2 && flag == 1, "R8", cap1, c0 + 2);

        // R10: one-cycle low pulse caught on both edges
        cwe = 1'b1; cval = 1'b1; tick(1); cwe = 1'b0; cval = 1'b0;
        emode = 2'd3; dual = 1'b1; tick(2);
        ev = 1'b0; c0 = cnt; tick(1); ev = 1'b1; tick(4);
        chk(cap1 == c0 + 2, "R10", cap1, c0 + 2);
        chk(cap2 == c0 + 3, "R10", cap2, c0 + 3);

        // R9: interrupt follows enable
        ien = 1'b0; tick(1);
        chk(irq == 0, "R9", irq, 0);
        ien = 1'b1; tick(1);
        chk(irq == 1, "R9", irq, 1);

        tick(3);
        done = 1'b1;
        finish_run();
    end
endmodule